// File: doc/BRIEF.md
# Sinc3 Decimation Filter with Selectable Ratio

This block turns single-bit delta-sigma modulator streams into signed conversion words. Each channel runs a third-order sinc decimator: three integrators at the modulator rate and three combs at the output rate. A 4-bit select picks one of sixteen decimation ratios, and that one setting applies to every channel in the instance. Each clock cycle carries one modulator bit per channel, so the output data rate is the clock rate divided by the selected ratio N.

Each filter result is normalised by 1/N³ and then multiplied by a fixed gain factor for the selected ratio. The factor is 1.0 for powers of two and differs slightly from 1.0 for the other ratios. The scaled word is held in an output register. A one-cycle active-low ready strobe marks each time that register is updated. After a restart or a ratio change the filter starts from zero state. The first two words it delivers are unsettled, and the third is the first settled one. Every word reaches the holding register one data period after the filter produces it.

Top module: `sinc3_decim`

## Requirements
- R1: `rate_sel` code c selects the ratio N from this descending list, indexed by c from 0 to 15: 4096, 2048, 1024, 800, 768, 512, 400, 384, 256, 200, 192, 128, 96, 64, 48, 32.
- R2: The clock edge that samples a restart condition takes no modulator sample and is counted as edge 0. Edges 1, 2, ... each take one sample per channel. `drdy_n` is low for exactly one cycle after edge k·N for every k ≥ 2, and is high after every other edge.
- R3: A high `restart` sampled on an edge clears all integrator, comb and period state and leaves `data_out` unchanged. Timing and data then follow R2 and R5 again.
- R4: A value of `rate_sel` that differs from the ratio in use has the same effect as `restart` on the edge where it is sampled, and the new ratio applies from that edge onward.
- R5: The word delivered after edge (m+1)·N is the sinc3 response at sample m·N. The filter kernel has length 3N−2, and all samples before edge 1 count as zero. The words for m = 1 and m = 2 are unsettled but still delivered. For m ≥ 3, an input whose pattern period divides N gives exactly N³ times the mean input value.
- R6: The output word equals round(y · 2^(OUT_W−1) · K / N³), to within one LSB, where y is the R5 filter response and K is the R7 gain factor.
- R7: K = 1.0 for the power-of-two ratios, K = 1 + 2^-9 for 768, 384, 192, 96 and 48, and K = 0.9983778 for 800, 400 and 200.
- R8: Scaled values outside the signed OUT_W range are clamped to +2^(OUT_W−1)−1 or −2^(OUT_W−1).
- R9: After reset, `drdy_n` is high and `data_out` is zero. `data_out` changes only on the edge that drives `drdy_n` low.
- R10: All channels share the ratio and the ready strobe. Each channel's word depends only on its own input bit, and channel c occupies `data_out[c*OUT_W +: OUT_W]`.
- R11: An input bit of 1 counts as +1 and a bit of 0 counts as −1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock; one input bit per channel each cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous wake/restart; clears filter state |
| rate_sel | input | 4 | Decimation ratio select code |
| mod_bits | input | NUM_CH | One modulator bit per channel |
| drdy_n | output | 1 | Active-low one-cycle strobe when the holding register loads |
| data_out | output | NUM_CH*OUT_W | Packed signed output words, channel 0 in the low bits |

## Verification
The hardest case to reach from the ports is the settled word for ratios that are not powers of two. Its value depends both on the exact filter kernel and on the non-unity gain constants, and a bounded-random input gives no closed-form expectation. The stimulus therefore drives periodic patterns with period 2 or 4 on every ratio. Because every allowed ratio is a multiple of 4, the settled result is exactly N³ times the mean. The two unsettled words are predicted from the zero-history kernel, computed in closed form. Restart and ratio change are applied partway through a data period, and the run that follows must repeat the exact zero-state sequence.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;

   localparam int SINC_ORDER = 3;
   localparam int MAX_LOG2   = 12;
   localparam int ACC_W      = SINC_ORDER * MAX_LOG2 + 2;
   localparam int CNT_W      = MAX_LOG2;

   typedef enum logic [1:0] {
      GAIN_UNITY  = 2'd0,
      GAIN_THIRDS = 2'd1,
      GAIN_FIFTHS = 2'd2
   } gain_cls_e;

   // descending ratio table, code 0 = largest
   function automatic int unsigned ratio_of(input logic [3:0] code);
      case (code)
         4'd0:    return 4096;
         4'd1:    return 2048;
         4'd2:    return 1024;
         4'd3:    return 800;
         4'd4:    return 768;
         4'd5:    return 512;
         4'd6:    return 400;
         4'd7:    return 384;
         4'd8:    return 256;
         4'd9:    return 200;
         4'd10:   return 192;
         4'd11:   return 128;
         4'd12:   return 96;
         4'd13:   return 64;
         4'd14:   return 48;
         default: return 32;
      endcase
   endfunction

   // exponent of the power-of-two factor of the ratio
   function automatic int unsigned pow2_of(input logic [3:0] code);
      case (code)
         4'd0:    return 12;
         4'd1:    return 11;
         4'd2:    return 10;
         4'd3:    return 5;
         4'd4:    return 8;
         4'd5:    return 9;
         4'd6:    return 4;
         4'd7:    return 7;
         4'd8:    return 8;
         4'd9:    return 3;
         4'd10:   return 6;
         4'd11:   return 7;
         4'd12:   return 5;
         4'd13:   return 6;
         4'd14:   return 4;
         default: return 5;
      endcase
   endfunction

   // odd factor of the ratio: 1, 3 or 25
   function automatic gain_cls_e gain_class_of(input logic [3:0] code);
      case (code)
         4'd3, 4'd6, 4'd9:                return GAIN_FIFTHS;
         4'd4, 4'd7, 4'd10, 4'd12, 4'd14: return GAIN_THIRDS;
         default:                         return GAIN_UNITY;
      endcase
   endfunction

   // extra left shift that keeps the multiplier near 2^frac
   function automatic int unsigned exp_of(input gain_cls_e cls);
      case (cls)
         GAIN_THIRDS: return 5;
         GAIN_FIFTHS: return 14;
         default:     return 0;
      endcase
   endfunction

   // round(K / m^3 * 2^(frac + exp)); frac in 18..32
   function automatic logic [63:0] mult_of(input gain_cls_e cls, input int frac);
      logic [63:0] num;
      case (cls)
         GAIN_THIRDS: begin
            num = (64'd1 << (frac + 5)) + (64'd1 << (frac - 4)) + 64'd13;
            return num / 64'd27;
         end
         GAIN_FIFTHS: begin
            // K/15625 = 9983778 / (5^13 * 2^7)
            num = (64'd1 << (frac + 7)) * 64'd9983778 + 64'd610351562;
            return num / 64'd1220703125;
         end
         default: return 64'd1 << frac;
      endcase
   endfunction

endpackage

// File: rtl/sinc3_rate_ctl.sv
`timescale 1ns/1ps
module sinc3_rate_ctl
   import sinc3_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [3:0] rate_sel,
   output logic [3:0] rate_q,
   output logic       clr,
   output logic       dec,
   output logic       load,
   output logic       drdy_n
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             have_res;

   assign last = CNT_W'(ratio_of(rate_q) - 1);
   assign clr  = restart | (rate_sel != rate_q);
   assign dec  = !clr && (cnt == last);
   assign load = dec && have_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q   <= 4'd0;
         cnt      <= '0;
         have_res <= 1'b0;
         drdy_n   <= 1'b1;
      end else if (clr) begin
         rate_q   <= rate_sel;
         cnt      <= '0;
         have_res <= 1'b0;
         drdy_n   <= 1'b1;
      end else begin
         cnt    <= dec ? '0 : cnt + 1'b1;
         drdy_n <= !load;
         if (dec)
            have_res <= 1'b1;
      end
   end

endmodule

// File: rtl/sinc3_chan.sv
`timescale 1ns/1ps
module sinc3_chan
   import sinc3_pkg::*;
#(
   parameter int ORDER = SINC_ORDER,
   parameter int AW    = ACC_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 dec,
   input  logic                 bit_in,
   output logic signed [AW-1:0] result
);

   typedef logic signed [AW-1:0] acc_t;

   acc_t sample;
   acc_t integ_q [ORDER];
   acc_t integ_d [ORDER];
   acc_t comb_q  [ORDER];
   acc_t comb_d  [ORDER+1];

   always_comb begin
      sample     = bit_in ? acc_t'(1) : '1;
      integ_d[0] = integ_q[0] + sample;
      for (int s = 1; s < ORDER; s++)
         integ_d[s] = integ_q[s] + integ_d[s-1];
      comb_d[0] = integ_d[ORDER-1];
      for (int s = 0; s < ORDER; s++)
         comb_d[s+1] = comb_d[s] - comb_q[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < ORDER; s++) begin
            integ_q[s] <= '0;
            comb_q[s]  <= '0;
         end
         result <= '0;
      end else if (clr) begin
         for (int s = 0; s < ORDER; s++) begin
            integ_q[s] <= '0;
            comb_q[s]  <= '0;
         end
         result <= '0;
      end else begin
         for (int s = 0; s < ORDER; s++)
            integ_q[s] <= integ_d[s];
         if (dec) begin
            for (int s = 0; s < ORDER; s++)
               comb_q[s] <= comb_d[s];
            result <= comb_d[ORDER];
         end
      end
   end

endmodule

// File: rtl/sinc3_scale.sv
`timescale 1ns/1ps
module sinc3_scale
   import sinc3_pkg::*;
#(
   parameter int AW       = ACC_W,
   parameter int OUT_W    = 24,
   parameter int GAIN_F   = 32,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic [3:0]              rate_q,
   input  logic signed [AW-1:0]    acc_in,
   output logic signed [OUT_W-1:0] word
);

   localparam int MUL_W = GAIN_F + 2;
   localparam int PW    = AW + MUL_W;

   gain_cls_e               cls;
   logic signed [MUL_W-1:0] mult_s;
   logic [7:0]              sh;
   logic signed [PW-1:0]    prod;
   logic signed [PW-1:0]    rounded;
   logic signed [PW-1:0]    shifted;
   logic                    fits;

   assign cls    = gain_class_of(rate_q);
   assign mult_s = MUL_W'(mult_of(cls, GAIN_F));
   assign sh     = 8'(3 * pow2_of(rate_q) + exp_of(cls) + GAIN_F - (OUT_W - 1));
   assign prod   = PW'(acc_in) * PW'(mult_s);

   if (ROUND_EN) begin : g_round
      assign rounded = prod + (PW'(1) << (sh - 8'd1));
   end else begin : g_trunc
      assign rounded = prod;
   end

   assign shifted = rounded >>> sh;
   assign fits    = (shifted[PW-1:OUT_W-1] == '0) || (shifted[PW-1:OUT_W-1] == '1);

   always_comb begin
      if (fits)
         word = shifted[OUT_W-1:0];
      else if (shifted[PW-1])
         word = {1'b1, {(OUT_W-1){1'b0}}};
      else
         word = {1'b0, {(OUT_W-1){1'b1}}};
   end

endmodule

// File: rtl/sinc3_decim.sv
`timescale 1ns/1ps
module sinc3_decim
   import sinc3_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int OUT_W    = 24,
   parameter int GAIN_F   = 32,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    restart,
   input  logic [3:0]              rate_sel,
   input  logic [NUM_CH-1:0]       mod_bits,
   output logic                    drdy_n,
   output logic [NUM_CH*OUT_W-1:0] data_out
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("sinc3_decim: NUM_CH must be at least 1");
   end
   if (GAIN_F < 18 || GAIN_F > 32) begin : g_bad_frac
      $error("sinc3_decim: GAIN_F must lie in 18..32");
   end
   if (OUT_W < 8 || OUT_W > 32) begin : g_bad_width
      $error("sinc3_decim: OUT_W must lie in 8..32");
   end

   logic [3:0] rate_q;
   logic       clr;
   logic       dec;
   logic       load;

   sinc3_rate_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .rate_sel (rate_sel),
      .rate_q   (rate_q),
      .clr      (clr),
      .dec      (dec),
      .load     (load),
      .drdy_n   (drdy_n)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic signed [ACC_W-1:0] filt;
      logic signed [OUT_W-1:0] scaled;
      logic signed [OUT_W-1:0] hold;

      sinc3_chan u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .dec    (dec),
         .bit_in (mod_bits[g]),
         .result (filt)
      );

      sinc3_scale #(
         .AW       (ACC_W),
         .OUT_W    (OUT_W),
         .GAIN_F   (GAIN_F),
         .ROUND_EN (ROUND_EN)
      ) u_scale (
         .rate_q (rate_q),
         .acc_in (filt),
         .word   (scaled)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold <= '0;
         else if (load)
            hold <= scaled;
      end

      assign data_out[g*OUT_W +: OUT_W] = hold;
   end

endmodule

// File: rtl/sinc3_decim_chk.sv
`timescale 1ns/1ps
module sinc3_decim_chk
   import sinc3_pkg::*;
#(
   parameter int DW = 48
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic [3:0]    rate_q,
   input logic          drdy_n,
   input logic [DW-1:0] data_out
);

   logic [13:0] gap;
   logic [13:0] per;
   logic        seen;

   assign per = 14'(ratio_of(rate_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (clr) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (!drdy_n) begin
         gap  <= 14'd1;
         seen <= 1'b1;
      end else begin
         gap <= gap + 14'd1;
      end
   end

   // R2
   first_strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drdy_n && !seen) |-> (gap == {per[12:0], 1'b0}));

   // R2
   strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drdy_n && seen) |-> (gap == per));

   // R2
   no_missed_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= (seen ? per : {per[12:0], 1'b0}));

   // R2
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drdy_n |=> drdy_n);

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drdy_n |-> $stable(data_out));

   // R3
   clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (drdy_n && $stable(data_out)));

endmodule

bind sinc3_decim sinc3_decim_chk #(.DW(NUM_CH*OUT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .rate_q   (rate_q),
   .drdy_n   (drdy_n),
   .data_out (data_out)
);

// File: tb/sim_sinc3_decim.sv
`timescale 1ns/1ps
module sim_sinc3_decim;

   localparam int NCH = 2;
   localparam int OW  = 24;

   logic                clk      = 1'b0;
   logic                rst_n    = 1'b0;
   logic                restart  = 1'b0;
   logic [3:0]          rate_sel = 4'd0;
   logic [NCH-1:0]      mod_bits = '0;
   logic                drdy_n;
   logic [NCH*OW-1:0]   data_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   sinc3_decim #(.NUM_CH(NCH), .OUT_W(OW)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .rate_sel (rate_sel),
      .mod_bits (mod_bits),
      .drdy_n   (drdy_n),
      .data_out (data_out)
   );

   // R1: expected ratio per code
   function automatic int exp_ratio(input int code);
      int tbl [16] = '{4096, 2048, 1024, 800, 768, 512, 400, 384,
                       256, 200, 192, 128, 96, 64, 48, 32};
      return tbl[code];
   endfunction

   // R7: gain factor per ratio
   function automatic real gain_k(input int n);
      if ((n & (n - 1)) == 0) return 1.0;
      if (n % 25 == 0)        return 0.9983778;
      return 1.0 + 1.0 / 512.0;
   endfunction

   // R11: bit 1 -> +1, bit 0 -> -1; all patterns have period 1, 2 or 4
   function automatic bit pat_bit(input int p, input int j);
      case (p)
         0:       return 1'b1;
         1:       return 1'b0;
         2:       return (j % 2) == 1;
         3:       return (j % 4) != 0;
         default: return (j % 4) == 1;
      endcase
   endfunction

   function automatic longint tri_n(input longint i);
      return (i + 2) * (i + 1) / 2;
   endfunction

   // sinc3 kernel tap i of length 3n-2
   function automatic longint kern(input longint n, input longint i);
      longint h;
      h = tri_n(i);
      if (i >= n)     h = h - 3 * tri_n(i - n);
      if (i >= 2 * n) h = h + 3 * tri_n(i - 2 * n);
      return h;
   endfunction

   // R5/R6/R8: expected word for result m (1-based), zero history
   function automatic longint exp_word(input int p, input int n, input int m);
      longint y = 0;
      longint e;
      longint lo;
      real    v;
      real    nr;
      lo = longint'(m) * n - 3 * n + 3;
      if (lo < 1) lo = 1;
      for (longint j = lo; j <= longint'(m) * n; j++)
         y += (pat_bit(p, int'(j)) ? 64'sd1 : -64'sd1) * kern(n, longint'(m) * n - j);
      nr = real'(n);
      v  = real'(y) * (2.0 ** (OW - 1)) * gain_k(n) / (nr * nr * nr);
      e  = longint'(v);
      if (e >  (64'sd1 <<< (OW - 1)) - 1) e = (64'sd1 <<< (OW - 1)) - 1;
      if (e < -(64'sd1 <<< (OW - 1)))     e = -(64'sd1 <<< (OW - 1));
      return e;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic run(input int code, input bit use_rst, input int pa, input int pb,
                      input int nsamp);
      int n = exp_ratio(code);
      int bad_strobe = 0;
      int bad_hold = 0;
      logic [NCH*OW-1:0] prev;
      @(negedge clk);
      rate_sel = 4'(code);
      restart  = use_rst;
      prev     = data_out;
      @(posedge clk);            // clearing edge, edge 0
      @(negedge clk);
      restart = 1'b0;
      // R3/R4: clearing edge keeps the output and gives no strobe
      check(drdy_n === 1'b1 && data_out === prev, "R3 R4 clear edge quiet",
            longint'(drdy_n), 1);
      for (int s = 1; s <= nsamp; s++) begin
         mod_bits[0] = pat_bit(pa, s);
         mod_bits[1] = pat_bit(pb, s);
         @(posedge clk);
         @(negedge clk);
         if (s >= 2 * n && (s % n) == 0) begin
            if (drdy_n !== 1'b0) begin
               bad_strobe++;
            end else begin
               int m = s / n - 1;
               for (int ch = 0; ch < NCH; ch++) begin
                  longint act = longint'($signed(data_out[ch*OW +: OW]));
                  longint ev  = exp_word(ch == 0 ? pa : pb, n, m);
                  longint d   = act - ev;
                  string  tag;
                  if (ev == (64'sd1 <<< (OW - 1)) - 1 || ev == -(64'sd1 <<< (OW - 1)))
                     tag = "R8 saturation";
                  else if (m <= 2)
                     tag = "R5 unsettled word";
                  else if (gain_k(n) != 1.0)
                     tag = "R7 gain factor";
                  else
                     tag = "R6 settled word";
                  check(d >= -1 && d <= 1,
                        $sformatf("%s R10 R11 code %0d ch %0d result %0d", tag, code, ch, m),
                        act, ev);
               end
            end
         end else begin
            if (drdy_n !== 1'b1) bad_strobe++;
            if (data_out !== prev) bad_hold++;
         end
         prev = data_out;
      end
      check(bad_strobe == 0, $sformatf("R1 R2 strobe timing code %0d", code), bad_strobe, 0);
      check(bad_hold == 0, $sformatf("R9 hold between strobes code %0d", code), bad_hold, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9: reset state
      check(drdy_n === 1'b1, "R9 reset drdy_n", longint'(drdy_n), 1);
      check(data_out === '0, "R9 reset data_out", longint'(data_out[OW-1:0]), 0);
      rst_n = 1'b1;

      // R1/R2/R5..R8/R10/R11: every ratio code, two patterns per run
      for (int c = 0; c < 16; c++)
         run(c, 1'b1, c % 5, (c + 2) % 5, 5 * exp_ratio(c));

      // R3: restart partway through a period, then a full clean run
      run(13, 1'b1, 3, 4, 96);
      run(13, 1'b1, 3, 4, 5 * exp_ratio(13));

      // R4: ratio change alone, partway through a period
      run(15, 1'b1, 0, 1, 80);
      run(12, 1'b0, 2, 3, 5 * exp_ratio(12));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule